// File: doc/BRIEF.md
# Synchronized SPI Target Port with Flag Handshake

An 8-bit SPI target (slave) peripheral. An external controller supplies the serial clock, the serial data in and an active-low select. The port shifts one byte out on its serial data output at the same time as it shifts one byte in. All four clock polarity and phase combinations are supported, and bits move most significant first. The pins are brought into the system clock domain through flop chains, and their edges are found there. The system clock must therefore run at least four times the serial clock rate.

Software sees three registers on a small parallel bus: control, status and data. A finished byte raises a completion flag and, if enabled, an interrupt line. The flag is released by a two-step handshake. Software first reads status while the flag is up, then reads or writes the data register. Until the status read has happened, data writes are dropped. If a second byte finishes before the handshake, the overrun bit is set.

Top module: `spi_target_port`

## Requirements
- R1: Register addresses are control=0, status=1, data=2. Control bits are [0] enable, [1] controller-select, [2] idle clock level (CPOL), [3] phase (CPHA), [4] interrupt enable. Status bits are [7] completion flag and [6] overrun, with all other bits reading 0. After reset, every register reads 0, the interrupt line is low and the serial output is low.
- R2: In each of the four CPOL/CPHA modes, one byte is received MSB first and the byte loaded into the data register is sent MSB first. After the transfer, a data read returns the received byte.
- R3: Serial activity has an effect only while enable=1 and controller-select=0. Otherwise the completion flag stays clear and the data register keeps its old value.
- R4: When the eighth bit is captured, the completion flag is set. The interrupt line equals the completion flag ANDed with interrupt enable.
- R5: A status read made while the flag is set, followed by any data-register access, clears both the flag and overrun. A data access with no such earlier status read leaves the flag set, and a status read made while the flag is clear arms nothing.
- R6: A data write made while the flag is set and no status read has armed the clear is ignored. A write made after arming is loaded and sent in the next transfer.
- R7: If a byte completes while the flag is still set, overrun is set and the data register keeps the earlier byte.
- R8: With CPHA=0, raising select restarts the bit count, so a partial byte is discarded. With CPHA=1, select may stay low across consecutive bytes.
- R9: A completing clock edge on the pin changes the flags at the third rising system clock edge after the pin changes. If a clearing data access acts in that same cycle, the new byte wins: the flag stays set, the data register takes the new byte and overrun stays clear.
- R10: Clock edges seen while select is high neither shift the outgoing byte nor count bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational while bus_en is high |
| irq | output | 1 | Interrupt request |
| sck_in | input | 1 | Serial clock from the controller |
| mosi_in | input | 1 | Serial data in |
| ss_n_in | input | 1 | Active-low select |
| miso_out | output | 1 | Serial data out |

## Verification
Two events can land in the same system cycle: a byte completing and the data access that finishes the clear handshake. The bench arms the clear with a status read, then drives the final capturing clock edge. It places the data access 0 to 4 cycles after that edge, which sweeps the access from before the completion, through the exact same cycle, to after it. For each offset, the status and data registers are then read back. Offsets up to the coinciding cycle must show the new byte with the flag set. Later offsets must show the older byte with everything cleared, because the overrun there is released by the same access.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;
   localparam int ADDR_CTRL = 0;
   localparam int ADDR_STAT = 1;
   localparam int ADDR_DATA = 2;

   // field order fixes the control bit positions, LSB last
   typedef struct packed {
      logic irq_en;
      logic cpha;
      logic cpol;
      logic host_sel;
      logic enable;
   } ctrl_t;

   localparam int CTRL_BITS = $bits(ctrl_t);
endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
   parameter int                 WIDTH   = 3,
   parameter int                 STAGES  = 2,
   parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stg [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[0] <= RST_VAL;
            else        stg[0] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[g] <= RST_VAL;
            else        stg[g] <= stg[g-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_tgt_edge.sv
module spi_tgt_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_s,
   input  logic ss_n_s,
   input  logic cpol,
   input  logic cpha,
   input  logic active,
   output logic ss_low,
   output logic capture,
   output logic launch
);
   logic sck_prev;
   logic moved, lead, trail, live;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sck_prev <= 1'b0;
      else        sck_prev <= sck_s;

   assign ss_low  = ~ss_n_s;
   assign moved   = sck_s ^ sck_prev;
   assign lead    = moved & (sck_s != cpol);   // leaves the idle level
   assign trail   = moved & (sck_s == cpol);   // returns to the idle level
   assign live    = active & ss_low;
   assign capture = live & (cpha ? trail : lead);
   assign launch  = live & (cpha ? lead  : trail);
endmodule

// File: rtl/spi_tgt_shift.sv
module spi_tgt_shift #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              ss_low,
   input  logic              cpha,
   input  logic              capture,
   input  logic              launch,
   input  logic              mosi_s,
   input  logic              tx_load,
   input  logic [DATA_W-1:0] tx_data,
   output logic              miso,
   output logic              byte_done,
   output logic [DATA_W-1:0] rx_byte
);
   localparam int            CNT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   logic [DATA_W-1:0] tx_sr, rx_sr;
   logic [CNT_W-1:0]  cnt;
   logic              miso_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sr  <= '0;
         miso_q <= 1'b0;
      end else if (tx_load) begin
         tx_sr  <= tx_data;
      end else if (launch) begin
         if (cpha) miso_q <= tx_sr[DATA_W-1];
         tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_sr <= '0;
         cnt   <= '0;
      end else if (!ss_low || !active) begin
         cnt   <= '0;
      end else if (capture) begin
         rx_sr <= {rx_sr[DATA_W-2:0], mosi_s};
         cnt   <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end
   end

   assign byte_done = capture & (cnt == LAST);
   assign rx_byte   = {rx_sr[DATA_W-2:0], mosi_s};
   assign miso      = cpha ? miso_q : tx_sr[DATA_W-1];
endmodule

// File: rtl/spi_tgt_regs.sv
module spi_tgt_regs
   import spi_tgt_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              byte_done,
   input  logic [DATA_W-1:0] rx_byte,
   output logic              tx_load,
   output ctrl_t             ctrl,
   output logic              done,
   output logic              ovr,
   output logic [DATA_W-1:0] rx_hold,
   output logic              irq
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);
   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(ADDR_DATA);

   ctrl_t             ctrl_q;
   logic              done_q, ovr_q, armed_q;
   logic [DATA_W-1:0] rx_q;
   logic              sel_ctrl, sel_stat, sel_data, clear_now;

   assign sel_ctrl  = bus_en && (bus_addr == A_CTRL);
   assign sel_stat  = bus_en && (bus_addr == A_STAT);
   assign sel_data  = bus_en && (bus_addr == A_DATA);
   assign clear_now = armed_q && sel_data;
   assign tx_load   = sel_data && bus_we && (!done_q || armed_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         done_q  <= 1'b0;
         ovr_q   <= 1'b0;
         armed_q <= 1'b0;
         rx_q    <= '0;
      end else begin
         if (sel_ctrl && bus_we)
            ctrl_q <= ctrl_t'(bus_wdata[CTRL_BITS-1:0]);
         if (sel_stat && !bus_we && done_q)
            armed_q <= 1'b1;
         if (clear_now) begin
            done_q  <= 1'b0;
            ovr_q   <= 1'b0;
            armed_q <= 1'b0;
         end
         if (byte_done) begin
            if (done_q && !clear_now) begin
               ovr_q <= 1'b1;
            end else begin
               rx_q   <= rx_byte;
               done_q <= 1'b1;
            end
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_en && !bus_we) begin
         case (bus_addr)
            A_CTRL: bus_rdata[CTRL_BITS-1:0] = ctrl_q;
            A_STAT: begin
               bus_rdata[DATA_W-1] = done_q;
               bus_rdata[DATA_W-2] = ovr_q;
            end
            A_DATA: bus_rdata = rx_q;
            default: bus_rdata = '0;
         endcase
      end
   end

   assign ctrl    = ctrl_q;
   assign done    = done_q;
   assign ovr     = ovr_q;
   assign rx_hold = rx_q;
   assign irq     = done_q & ctrl_q.irq_en;
endmodule

// File: rtl/spi_target_port.sv
module spi_target_port
   import spi_tgt_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq,
   input  logic              sck_in,
   input  logic              mosi_in,
   input  logic              ss_n_in,
   output logic              miso_out
);
   if (DATA_W < CTRL_BITS) begin : g_chk_width
      $error("DATA_W must hold the control fields");
   end
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (ADDR_W < 2) begin : g_chk_addr
      $error("ADDR_W must be at least 2");
   end

   logic [2:0]        pins_s;
   logic              sck_s, mosi_s, ss_n_s;
   ctrl_t             ctrl;
   logic              core_active, ss_low, capture, launch;
   logic              byte_done, tx_load, st_done, st_ovr;
   logic [DATA_W-1:0] rx_byte, rx_hold;

   spi_tgt_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({ss_n_in, mosi_in, sck_in}), .q(pins_s)
   );
   assign {ss_n_s, mosi_s, sck_s} = pins_s;

   assign core_active = ctrl.enable & ~ctrl.host_sel;

   spi_tgt_edge u_edge (
      .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .ss_n_s(ss_n_s),
      .cpol(ctrl.cpol), .cpha(ctrl.cpha), .active(core_active),
      .ss_low(ss_low), .capture(capture), .launch(launch)
   );

   spi_tgt_shift #(.DATA_W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .active(core_active), .ss_low(ss_low),
      .cpha(ctrl.cpha), .capture(capture), .launch(launch), .mosi_s(mosi_s),
      .tx_load(tx_load), .tx_data(bus_wdata), .miso(miso_out),
      .byte_done(byte_done), .rx_byte(rx_byte)
   );

   spi_tgt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .byte_done(byte_done), .rx_byte(rx_byte), .tx_load(tx_load),
      .ctrl(ctrl), .done(st_done), .ovr(st_ovr), .rx_hold(rx_hold), .irq(irq)
   );
endmodule

// File: rtl/spi_target_port_chk.sv
module spi_target_port_chk
   import spi_tgt_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_en,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              done,
   input logic              ovr,
   input logic              active,
   input logic              irq,
   input logic [DATA_W-1:0] rx
);
   assert_ovr_implies_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ovr |-> done);

   assert_ovr_needs_prior_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr) |-> $past(done));

   assert_rx_held_on_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr) |-> $stable(rx));

   assert_done_cleared_by_data_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(done) |-> $past(bus_en && (bus_addr == ADDR_W'(ADDR_DATA))));

   assert_done_needs_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(active));

   assert_irq_only_with_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> done);
endmodule

bind spi_target_port spi_target_port_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_addr(bus_addr),
   .done(st_done), .ovr(st_ovr), .active(core_active), .irq(irq), .rx(rx_hold)
);

// File: tb/sim_spi_target_port.sv
module sim_spi_target_port;
   localparam int H = 8;
   localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2;
   // {cpol, cpha, byte from controller, byte loaded in the port}
   localparam logic [17:0] VEC [8] = '{
      {2'b00, 8'hA5, 8'h3C}, {2'b01, 8'h5A, 8'hC3},
      {2'b10, 8'h81, 8'h7E}, {2'b11, 8'h7E, 8'h81},
      {2'b00, 8'hFF, 8'h00}, {2'b01, 8'h00, 8'hFF},
      {2'b10, 8'h96, 8'h69}, {2'b11, 8'h13, 8'hEC}};

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       bus_en = 1'b0, bus_we = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0, bus_rdata;
   logic       irq, miso_out;
   logic       sck = 1'b0, mosi = 1'b0, ss_n = 1'b1;
   logic       cur_cpol = 1'b0, cur_cpha = 1'b0;
   int         nchk = 0, nfail = 0;

   always #5 clk = ~clk;

   spi_target_port u0 (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .sck_in(sck), .mosi_in(mosi), .ss_n_in(ss_n), .miso_out(miso_out)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: got %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_en = 1'b0;
   endtask

   task automatic set_mode(input logic [7:0] c);
      cur_cpol = c[2]; cur_cpha = c[3];
      bus_wr(A_CTRL, c);
   endtask

   task automatic xfer(input logic [7:0] mo, input int nbits, input bit keep_low,
                       input int clr_d, output logic [7:0] mi);
      logic [7:0] dmy;
      mi = '0;
      sck = cur_cpol;
      repeat (4) @(negedge clk);
      ss_n = 1'b0;
      repeat (H) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         if (!cur_cpha) begin
            mosi = mo[7-i];
            repeat (H) @(negedge clk);
            mi[7-i] = miso_out;
            sck = ~cur_cpol;
            if (clr_d >= 0 && i == nbits - 1) begin
               repeat (clr_d) @(negedge clk);
               bus_rd(A_DATA, dmy);
            end
            repeat (H) @(negedge clk);
            sck = cur_cpol;
         end else begin
            sck = ~cur_cpol;
            mosi = mo[7-i];
            repeat (H) @(negedge clk);
            mi[7-i] = miso_out;
            sck = cur_cpol;
            repeat (H) @(negedge clk);
         end
      end
      repeat (H) @(negedge clk);
      if (!keep_low) ss_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      logic [7:0] rd, mi;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      bus_rd(A_CTRL, rd); check("R1 ctrl", rd, 8'h00);
      bus_rd(A_STAT, rd); check("R1 status", rd, 8'h00);
      bus_rd(A_DATA, rd); check("R1 data", rd, 8'h00);
      check("R1 irq/miso", {6'b0, irq, miso_out}, 8'h00);

      // R2/R4 vector table over all modes
      foreach (VEC[k]) begin
         set_mode(8'h11 | {4'b0, VEC[k][16], VEC[k][17], 2'b00});
         bus_rd(A_STAT, rd);
         bus_rd(A_DATA, rd);
         bus_wr(A_DATA, VEC[k][7:0]);
         xfer(VEC[k][15:8], 8, 1'b0, -1, mi);
         check("R2 sent byte", mi, VEC[k][7:0]);
         check("R4 irq", {7'b0, irq}, 8'h01);
         bus_rd(A_STAT, rd); check("R4 status", rd, 8'h80);
         bus_rd(A_DATA, rd); check("R2 received byte", rd, VEC[k][15:8]);
      end

      // R4: no interrupt when disabled in control
      set_mode(8'h01);
      xfer(8'h3A, 8, 1'b0, -1, mi);
      check("R4 irq masked", {7'b0, irq}, 8'h00);

      // R5: data access without arming keeps flag; armed write clears
      bus_rd(A_DATA, rd);
      bus_rd(A_STAT, rd); check("R5 flag kept", rd, 8'h80);
      bus_wr(A_DATA, 8'hC3);
      bus_rd(A_STAT, rd); check("R5 cleared", rd, 8'h00);
      xfer(8'h11, 8, 1'b0, -1, mi);
      check("R6 armed write sent", mi, 8'hC3);
      set_mode(8'h11);
      bus_rd(A_DATA, rd);
      check("R5 no arm from clear status", {7'b0, irq}, 8'h01);

      // R6: write dropped while flag pending
      bus_wr(A_DATA, 8'h5A);
      bus_rd(A_STAT, rd);
      bus_rd(A_DATA, rd); check("R6 data", rd, 8'h11);
      xfer(8'h22, 8, 1'b0, -1, mi);
      check("R6 blocked write", mi, 8'h00);

      // R7 overrun
      xfer(8'h33, 8, 1'b0, -1, mi);
      bus_rd(A_STAT, rd); check("R7 overrun status", rd, 8'hC0);
      bus_rd(A_DATA, rd); check("R7 first byte kept", rd, 8'h22);
      bus_rd(A_STAT, rd); check("R5 overrun cleared", rd, 8'h00);

      // R3 inactive configurations
      set_mode(8'h00);
      xfer(8'h44, 8, 1'b0, -1, mi);
      bus_rd(A_STAT, rd); check("R3 disabled status", rd, 8'h00);
      bus_rd(A_DATA, rd); check("R3 disabled data", rd, 8'h22);
      set_mode(8'h03);
      xfer(8'h45, 8, 1'b0, -1, mi);
      bus_rd(A_STAT, rd); check("R3 controller-select status", rd, 8'h00);
      bus_rd(A_DATA, rd); check("R3 controller-select data", rd, 8'h22);

      // R10 edges with select high
      set_mode(8'h01);
      bus_wr(A_DATA, 8'hA5);
      for (int t = 0; t < 16; t++) begin
         sck = ~sck;
         repeat (H) @(negedge clk);
      end
      sck = 1'b0;
      repeat (4) @(negedge clk);
      bus_rd(A_STAT, rd); check("R10 no count", rd, 8'h00);
      xfer(8'h5C, 8, 1'b0, -1, mi);
      check("R10 byte unshifted", mi, 8'hA5);
      bus_rd(A_STAT, rd);
      bus_rd(A_DATA, rd); check("R10 receive", rd, 8'h5C);

      // R8 partial byte discarded with CPHA=0
      xfer(8'h0F, 3, 1'b0, -1, mi);
      xfer(8'hE7, 8, 1'b0, -1, mi);
      bus_rd(A_STAT, rd); check("R8 one byte only", rd, 8'h80);
      bus_rd(A_DATA, rd); check("R8 restart", rd, 8'hE7);

      // R8 CPHA=1 back to back with select held low
      set_mode(8'h09);
      bus_wr(A_DATA, 8'h4D);
      xfer(8'hB2, 8, 1'b1, -1, mi);
      check("R8 first sent", mi, 8'h4D);
      bus_rd(A_STAT, rd);
      bus_rd(A_DATA, rd); check("R8 first received", rd, 8'hB2);
      bus_wr(A_DATA, 8'hD4);
      xfer(8'h2B, 8, 1'b0, -1, mi);
      check("R8 second sent", mi, 8'hD4);
      bus_rd(A_STAT, rd); check("R8 second status", rd, 8'h80);
      bus_rd(A_DATA, rd); check("R8 second received", rd, 8'h2B);

      // R9 clear access swept around the completing cycle
      set_mode(8'h01);
      for (int d = 0; d < 5; d++) begin
         bus_rd(A_STAT, rd);
         bus_rd(A_DATA, rd);
         xfer(8'h61, 8, 1'b0, -1, mi);
         bus_rd(A_STAT, rd);
         xfer(8'h9E, 8, 1'b0, d, mi);
         bus_rd(A_STAT, rd);
         check($sformatf("R9 status d=%0d", d), rd, (d <= 2) ? 8'h80 : 8'h00);
         bus_rd(A_DATA, rd);
         check($sformatf("R9 data d=%0d", d), rd, (d <= 2) ? 8'h9E : 8'h61);
      end

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule